// File: doc/BRIEF.md
# Scanline Mode Timing Generator

This block produces the raster timing of a small display controller from a free-running clock and a dot-rate enable. Within each line it keeps a dot position, and across lines it keeps a line number. From these two values it derives a two-bit mode that tells the rest of the display pipeline what is currently allowed: object search, pixel transfer, horizontal blank, or vertical blank. Neighbouring blocks take the mode, the line number and two single-cycle strobes, one at each horizontal-blank start and one at each vertical-blank start. A copy engine can pace its work from these strobes, and the frame presenter can use them as well.

A four-entry register port lets the processor turn the timing on and off, choose which events raise the status interrupt, read the current line, and set a line-compare value. The block has two interrupt request outputs. One is a vertical-blank request. The other is a shared status request, and it fires only on the cycle after one of its enabled sources begins. Pixel rendering and memory arbitration are handled by other blocks.

Top module: `scan_timing_gen`

## Requirements
- R1: A line is 456 dots and a frame is 154 lines (70224 dots). The line number counts 0 to 153 and then returns to 0. The counters advance only in clock cycles where `dot_en` is high. While `dot_en` is low they hold, and no mode entry occurs.
- R2: On lines 0 to 143, dots 0 to 79 are mode 2 (object search), dots 80 to 251 are mode 3 (pixel transfer), and dots 252 to 455 are mode 0 (horizontal blank).
- R3: Every dot of lines 144 to 153 is mode 1 (vertical blank).
- R4: The register map is as follows. Address 0 is control: bit 7 is the run enable and the other bits read 0. Address 1 is status: bits 1..0 give the mode code (0 hblank, 1 vblank, 2 search, 3 transfer), bit 2 is the coincidence flag, bit 6 enables the coincidence source, bit 5 enables mode 2 entry, bit 4 enables mode 1 entry, bit 3 enables mode 0 entry, and bit 7 reads 0. Address 2 is the line number. Address 3 is the line-compare value. Reads are combinational from `reg_addr`, and all registers reset to 0.
- R5: Status bit 2 reads 1 exactly when the line number equals the compare value. This holds while the timing is stopped too.
- R6: On entering mode 1, `irq_vblank` pulses for one cycle. If status bit 4 is set, `irq_stat` pulses in the same cycle. A pulse appears on the clock edge after the edge that moved the counters into the new mode.
- R7: With status bit 5 set, `irq_stat` pulses once on each entry to mode 2. With bit 3 set, it pulses once on each entry to mode 0. It never repeats while the mode stays the same.
- R8: With status bit 6 set, `irq_stat` pulses when the line number and the compare value start to be equal. This includes a write to the compare register that makes them equal.
- R9: When several enabled status sources begin in the same cycle, `irq_stat` gives a single one-cycle pulse.
- R10: Writing 0 to control bit 7 stops the timing. Within two cycles the dot count and line number are 0 and the mode is 0, and no interrupt fires while the timing is stopped. Writing 1 restarts the timing at line 0, dot 0, in mode 2.
- R11: Writes to status bits 2..0 and to the line-number register have no effect.
- R12: `hblank_stb` pulses for one cycle on each entry to mode 0, and `vblank_stb` pulses for one cycle on each entry to mode 1. Both are independent of the interrupt enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Dot-rate enable; one dot per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 line, 3 compare) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mode | output | 2 | Current mode code |
| ly | output | 8 | Current line number |
| hblank_stb | output | 1 | One-cycle strobe at horizontal-blank entry |
| vblank_stb | output | 1 | One-cycle strobe at vertical-blank entry |
| irq_vblank | output | 1 | Vertical-blank interrupt request pulse |
| irq_stat | output | 1 | Status interrupt request pulse |

## Verification
The coincidence source and the mode 2 entry source both start on the cycle a new line begins, so they can fall in the same cycle. The bench sets the compare value to 5 and enables both sources. It then expects exactly one status pulse at the start of every visible line, including line 5, and checks that no second pulse follows at line 5. A second collision happens when vertical blank is entered with the mode 1 source enabled: both request outputs must rise together on the predicted cycle, and the scoreboard treats them as a single event.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

   typedef enum logic [1:0] {
      MODE_HBLANK = 2'd0,
      MODE_VBLANK = 2'd1,
      MODE_SEARCH = 2'd2,
      MODE_XFER   = 2'd3
   } scan_mode_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_LINE = 2'd2;
   localparam logic [1:0] ADDR_CMP  = 2'd3;

   // index into the interrupt enable vector
   localparam int SRC_HBLANK = 0;
   localparam int SRC_VBLANK = 1;
   localparam int SRC_SEARCH = 2;
   localparam int SRC_COINC  = 3;
   localparam int NUM_SRC    = 4;

endpackage

// File: rtl/scan_counters.sv
module scan_counters #(
   parameter int DOTS_PER_LINE = 456,
   parameter int TOTAL_LINES   = 154,
   parameter int DOT_W         = $clog2(DOTS_PER_LINE),
   parameter int LINE_W        = $clog2(TOTAL_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              dot_en,
   output logic [DOT_W-1:0]  dot,
   output logic [LINE_W-1:0] line
);

   localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS_PER_LINE - 1);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         dot  <= '0;
         line <= '0;
      end else if (dot_en) begin
         if (dot == LAST_DOT) begin
            dot  <= '0;
            line <= (line == LAST_LINE) ? '0 : line + 1'b1;
         end else begin
            dot <= dot + 1'b1;
         end
      end
   end

endmodule

// File: rtl/scan_mode_decode.sv
module scan_mode_decode
   import scan_timing_pkg::*;
#(
   parameter int VIS_LINES  = 144,
   parameter int OAM_DOTS   = 80,
   parameter int XFER_DOTS  = 172,
   parameter int DOT_W      = 9,
   parameter int LINE_W     = 8
) (
   input  logic              run,
   input  logic [DOT_W-1:0]  dot,
   input  logic [LINE_W-1:0] line,
   output scan_mode_t        mode
);

   localparam logic [DOT_W-1:0]  XFER_START  = DOT_W'(OAM_DOTS);
   localparam logic [DOT_W-1:0]  HBLK_START  = DOT_W'(OAM_DOTS + XFER_DOTS);
   localparam logic [LINE_W-1:0] VBLK_START  = LINE_W'(VIS_LINES);

   always_comb begin
      if (!run)                    mode = MODE_HBLANK;
      else if (line >= VBLK_START) mode = MODE_VBLANK;
      else if (dot < XFER_START)   mode = MODE_SEARCH;
      else if (dot < HBLK_START)   mode = MODE_XFER;
      else                         mode = MODE_HBLANK;
   end

endmodule

// File: rtl/scan_irq_gen.sv
module scan_irq_gen
   import scan_timing_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  scan_mode_t         mode,
   input  logic               coinc,
   input  logic [NUM_SRC-1:0] irq_en,
   output logic               irq_vblank,
   output logic               irq_stat,
   output logic               hblank_stb,
   output logic               vblank_stb
);

   scan_mode_t         mode_prev;
   logic               coinc_prev;
   logic               entered;
   logic [NUM_SRC-1:0] src;
   logic [NUM_SRC-1:0] hit;

   assign entered = run && (mode != mode_prev);

   always_comb begin
      src             = '0;
      src[SRC_HBLANK] = entered && (mode == MODE_HBLANK);
      src[SRC_VBLANK] = entered && (mode == MODE_VBLANK);
      src[SRC_SEARCH] = entered && (mode == MODE_SEARCH);
      src[SRC_COINC]  = run && coinc && !coinc_prev;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = src[i] & irq_en[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_prev  <= MODE_HBLANK;
         coinc_prev <= 1'b0;
         irq_vblank <= 1'b0;
         irq_stat   <= 1'b0;
         hblank_stb <= 1'b0;
         vblank_stb <= 1'b0;
      end else begin
         mode_prev  <= mode;
         coinc_prev <= coinc;
         irq_vblank <= src[SRC_VBLANK];
         irq_stat   <= |hit;
         hblank_stb <= src[SRC_HBLANK];
         vblank_stb <= src[SRC_VBLANK];
      end
   end

endmodule

// File: rtl/scan_regs.sv
module scan_regs
   import scan_timing_pkg::*;
#(
   parameter int LINE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [7:0]         reg_wdata,
   input  scan_mode_t         mode,
   input  logic [LINE_W-1:0]  line,
   output logic [7:0]         reg_rdata,
   output logic               run,
   output logic [NUM_SRC-1:0] irq_en,
   output logic               coinc
);

   logic [7:0] cmp_q;
   logic [7:0] line_ext;

   assign line_ext = 8'(line);
   assign coinc    = (line_ext == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         irq_en <= '0;
         cmp_q  <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            ADDR_CTRL: run    <= reg_wdata[7];
            ADDR_STAT: irq_en <= reg_wdata[6:3];
            ADDR_CMP:  cmp_q  <= reg_wdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_CTRL: reg_rdata = {run, 7'd0};
         ADDR_STAT: reg_rdata = {1'b0, irq_en, coinc, mode};
         ADDR_LINE: reg_rdata = line_ext;
         default:   reg_rdata = cmp_q;
      endcase
   end

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
   import scan_timing_pkg::*;
#(
   parameter int DOTS_PER_LINE = 456,
   parameter int TOTAL_LINES   = 154,
   parameter int VIS_LINES     = 144,
   parameter int OAM_DOTS      = 80,
   parameter int XFER_DOTS     = 172
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dot_en,
   input  logic       reg_we,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic [1:0] mode,
   output logic [7:0] ly,
   output logic       hblank_stb,
   output logic       vblank_stb,
   output logic       irq_vblank,
   output logic       irq_stat
);

   localparam int DOT_W  = $clog2(DOTS_PER_LINE);
   localparam int LINE_W = $clog2(TOTAL_LINES);

   if (OAM_DOTS + XFER_DOTS >= DOTS_PER_LINE) begin : g_bad_dots
      $error("search plus transfer must leave room for horizontal blank");
   end
   if (VIS_LINES >= TOTAL_LINES) begin : g_bad_lines
      $error("visible lines must leave room for vertical blank");
   end
   if (LINE_W > 8) begin : g_bad_width
      $error("line number must fit the 8-bit register");
   end

   logic [DOT_W-1:0]   dot;
   logic [LINE_W-1:0]  line;
   logic               run;
   logic               coinc;
   logic [NUM_SRC-1:0] irq_en;
   scan_mode_t         mode_e;

   scan_counters #(
      .DOTS_PER_LINE (DOTS_PER_LINE),
      .TOTAL_LINES   (TOTAL_LINES),
      .DOT_W         (DOT_W),
      .LINE_W        (LINE_W)
   ) counters_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .dot_en (dot_en),
      .dot    (dot),
      .line   (line)
   );

   scan_mode_decode #(
      .VIS_LINES (VIS_LINES),
      .OAM_DOTS  (OAM_DOTS),
      .XFER_DOTS (XFER_DOTS),
      .DOT_W     (DOT_W),
      .LINE_W    (LINE_W)
   ) decode_i (
      .run  (run),
      .dot  (dot),
      .line (line),
      .mode (mode_e)
   );

   scan_regs #(
      .LINE_W (LINE_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .mode      (mode_e),
      .line      (line),
      .reg_rdata (reg_rdata),
      .run       (run),
      .irq_en    (irq_en),
      .coinc     (coinc)
   );

   scan_irq_gen irq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .mode       (mode_e),
      .coinc      (coinc),
      .irq_en     (irq_en),
      .irq_vblank (irq_vblank),
      .irq_stat   (irq_stat),
      .hblank_stb (hblank_stb),
      .vblank_stb (vblank_stb)
   );

   assign mode = mode_e;
   assign ly   = 8'(line);

endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dot_en,
   input logic       run,
   input logic [1:0] mode,
   input logic [7:0] ly,
   input logic       irq_vblank,
   input logic       irq_stat,
   input logic       hblank_stb,
   input logic       vblank_stb
);

   assert_ly_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ly <= 8'd153);

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !dot_en) |=> $stable(ly));

   assert_vblank_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ly >= 8'd144) |-> mode == 2'd1);

   assert_vblank_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vblank |=> !irq_vblank);

   assert_vblank_in_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vblank |-> mode == 2'd1);

   assert_stat_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_stat |=> !irq_stat);

   assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> (!irq_stat && !irq_vblank));

   assert_off_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> mode == 2'd0);

   assert_hstb_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
      hblank_stb |-> mode == 2'd0);

   assert_vstb_with_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_stb == irq_vblank);

endmodule

bind scan_timing_gen scan_timing_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .dot_en     (dot_en),
   .run        (run),
   .mode       (mode),
   .ly         (ly),
   .irq_vblank (irq_vblank),
   .irq_stat   (irq_stat),
   .hblank_stb (hblank_stb),
   .vblank_stb (vblank_stb)
);

// File: tb/scan_timing_gen_tb_top.sv
module scan_timing_gen_tb_top;

   localparam int LINE = 456;
   localparam int FRAME = LINE * 154;

   typedef struct {
      int    cyc;
      bit    stat;
      bit    vb;
      string req;
   } evt_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dot_en = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic [1:0] mode;
   logic [7:0] ly;
   logic       hblank_stb, vblank_stb, irq_vblank, irq_stat;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   int   hcnt = 0;
   int   vcnt = 0;
   int   last_wr = 0;
   bit   done = 1'b0;
   evt_t exp_q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   scan_timing_gen dut_i (
      .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mode(mode), .ly(ly), .hblank_stb(hblank_stb), .vblank_stb(vblank_stb),
      .irq_vblank(irq_vblank), .irq_stat(irq_stat)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic push(input int c, input bit s, input bit v, input string req);
      evt_t e;
      e.cyc = c; e.stat = s; e.vb = v; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      last_wr = cyc;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: every interrupt pulse must match the next expected event
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (hblank_stb) hcnt++;
         if (vblank_stb) vcnt++;
         if (irq_stat || irq_vblank) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected pulse", {irq_stat, irq_vblank}, 0);
            end else begin
               evt_t e;
               e = exp_q.pop_front();
               check(e.cyc == cyc, e.req, cyc, e.cyc);
               check(e.stat == irq_stat && e.vb == irq_vblank, e.req,
                     {irq_stat, irq_vblank}, {e.stat, e.vb});
            end
         end
      end
   end

   task automatic finish_run;
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] d;
      int e_on, f2, dis, e3;

      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state (R4, R5)
      rd(2'd0, d); check(d == 8'h00, "R4 ctrl reset", d, 8'h00);
      rd(2'd1, d); check(d == 8'h04, "R5 status reset", d, 8'h04);
      rd(2'd2, d); check(d == 8'h00, "R4 line reset", d, 8'h00);
      check(mode == 2'd0, "R10 mode while off", mode, 0);

      // read-only fields (R11)
      wr(2'd1, 8'hFF);
      rd(2'd1, d); check(d == 8'h7C, "R11 status ro bits", d, 8'h7C);
      wr(2'd2, 8'h55);
      rd(2'd2, d); check(d == 8'h00, "R11 line write ignored", d, 8'h00);

      // frame 1: coincidence on line 5 merged with search entry (R8, R9, R7)
      wr(2'd3, 8'd5);
      rd(2'd1, d); check(d == 8'h78, "R5 flag clears on mismatch", d, 8'h78);
      wr(2'd1, 8'h60);
      dot_en = 1'b1;
      wr(2'd0, 8'h80);
      e_on = last_wr;
      hcnt = 0; vcnt = 0;
      for (int l = 0; l < 144; l++)
         push(e_on + l*LINE + 1, 1'b1, 1'b0, (l == 5) ? "R9 merged line 5" : "R7 search entry");
      push(e_on + 144*LINE + 1, 1'b0, 1'b1, "R6 vblank only");

      wait_until(e_on + 300);
      check(mode == 2'd0 && ly == 8'd0, "R2 hblank dot 300", {ly, 6'd0, mode}, 0);
      rd(2'd1, d); check(d == 8'h60, "R4 status in hblank", d, 8'h60);
      wait_until(e_on + 5*LINE + 79);
      check(mode == 2'd2, "R2 search dot 79", mode, 2);
      wait_until(e_on + 5*LINE + 80);
      check(mode == 2'd3, "R2 transfer dot 80", mode, 3);
      rd(2'd1, d); check(d == 8'h67, "R5 status coincident", d, 8'h67);
      wait_until(e_on + 5*LINE + 251);
      check(mode == 2'd3, "R2 transfer dot 251", mode, 3);
      wait_until(e_on + 5*LINE + 252);
      check(mode == 2'd0, "R2 hblank dot 252", mode, 0);
      wait_until(e_on + 144*LINE + 10);
      check(mode == 2'd1, "R3 vblank line 144", mode, 1);
      rd(2'd2, d); check(d == 8'd144, "R1 line 144", d, 144);
      wait_until(e_on + 150*LINE);
      check(hcnt == 144, "R12 hblank strobes", hcnt, 144);
      check(vcnt == 1, "R12 vblank strobes", vcnt, 1);

      // frame 2: hblank and vblank status sources (R7, R6, R9)
      wr(2'd1, 8'h18);
      f2 = e_on + FRAME;
      for (int l = 0; l < 144; l++)
         push(f2 + l*LINE + 253, 1'b1, 1'b0, "R7 hblank entry");
      push(f2 + 144*LINE + 1, 1'b1, 1'b1, "R6 vblank with status");
      wait_until(e_on + 153*LINE + 455);
      check(ly == 8'd153 && mode == 2'd1, "R1 last line", ly, 153);
      wait_until(f2);
      check(ly == 8'd0 && mode == 2'd2, "R1 frame wrap", ly, 0);
      wait_until(f2 + 144*LINE + 50);

      // stop (R10)
      wr(2'd0, 8'h00);
      dis = last_wr;
      wait_until(dis + 2);
      check(ly == 8'd0 && mode == 2'd0, "R10 stop clears", {ly, 6'd0, mode}, 0);
      rd(2'd0, d); check(d == 8'h00, "R10 ctrl off", d, 0);
      repeat (20) @(negedge clk);

      // restart, stall, compare write (R10, R1, R8)
      wr(2'd1, 8'h20);
      wr(2'd0, 8'h80);
      e3 = last_wr;
      push(e3 + 1, 1'b1, 1'b0, "R10 restart search entry");
      check(mode == 2'd2 && ly == 8'd0, "R10 restart mode", mode, 2);
      wait_until(e3 + 20);
      dot_en = 1'b0;
      repeat (100) @(negedge clk);
      check(mode == 2'd2 && ly == 8'd0, "R1 stall holds", mode, 2);
      wr(2'd1, 8'h40);
      wr(2'd3, 8'd0);
      push(last_wr + 1, 1'b1, 1'b0, "R8 compare write match");
      repeat (100) @(negedge clk);
      check(mode == 2'd2, "R1 stall still search", mode, 2);
      dot_en = 1'b1;
      repeat (600) @(negedge clk);
      rd(2'd2, d); check(d == 8'd1, "R1 resumed count", d, 1);
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R7 all events seen", exp_q.size(), 0);
      finish_run();
   end

endmodule